// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block sequences a single-cell lithium charge cycle in a synchronous clock domain. It reads a set of comparator decisions that are already digital: supply present, supply headroom over the cell, cell above the deep-discharge level, cell above the recharge level, charge current under one tenth of its setpoint, a shutdown request, over-temperature and temperature-recovered. From these it chooses a current-regulation setpoint (off, low or full) for an analog loop, drives an active-low charging indicator, and reports its state.

Safety timers count ticks from an external time base. One counter serves every state. The limits for the trickle phase and the top-off phase are each one sixth of the bulk-charge limit. A cell that does not recover during trickle latches a fault, and only a supply cycle clears that fault. After top-off or a timeout, the block starts a new cycle when the cell sags or the current rises again. A strap input disables every timeout.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset the state is power-down, setpoint_o is off and stat_n_o is high. State codes on state_o are: 0 power-down, 1 start, 2 trickle, 3 bulk, 4 top-off, 5 timeout, 6 fault, 7 shutdown. Setpoint codes are 2'b00 off, 2'b01 low and 2'b10 full.
- R2: Loss of supply moves the block to power-down from any state, including fault. This entry wins over every other condition in the same cycle. When supply returns, the block enters start.
- R3: Start goes to bulk when the cell is above the deep-discharge level, and to trickle otherwise.
- R4: Trickle goes to bulk when the cell rises above the deep-discharge level. The shutdown request has no effect in trickle.
- R5: If the cell is still low after FAST_LIM/6 ticks in trickle, the block enters fault. Fault keeps the setpoint off. It ignores the cell flags and over-temperature, and it leaves only through power-down.
- R6: Bulk goes to top-off when the low-current flag and the recharge-level flag are both set. If FAST_LIM ticks pass in bulk first, the block enters timeout.
- R7: Top-off enters timeout after FAST_LIM/6 ticks. In top-off or timeout, the block goes back to start when the cell drops below the recharge level or the low-current flag clears.
- R8: A shutdown request moves start, bulk, top-off and timeout to shutdown. Shutdown returns to start only when the request is low and temperature-recovered is high.
- R9: Over-temperature forces shutdown from every state except power-down and fault.
- R10: With tmr_en_i low, no timeout fires, however many ticks arrive.
- R11: The setpoint is low in trickle and top-off, full in bulk, and off in every other state. It is also forced off while the headroom flag is low. stat_n_o is low only in trickle and bulk.
- R12: The tick counter clears on every state change, so each state gets its full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vin_ok_i | input | 1 | Supply present |
| vin_hdrm_i | input | 1 | Supply sufficiently above the cell |
| bat_pre_i | input | 1 | Cell above the deep-discharge level |
| bat_rch_i | input | 1 | Cell above the recharge level |
| i_low_i | input | 1 | Charge current below one tenth of setpoint |
| shdn_req_i | input | 1 | Shutdown request |
| ot_i | input | 1 | Over-temperature |
| t_rec_i | input | 1 | Temperature recovered |
| tmr_en_i | input | 1 | Timeout enable strap |
| tick_i | input | 1 | Single-cycle time-base pulse |
| setpoint_o | output | 2 | Current setpoint: 00 off, 01 low, 10 full |
| stat_n_o | output | 1 | Charging indicator, active low |
| state_o | output | 3 | Current state code |

## Verification
A wrong state shows on state_o three clock cycles after the flag change that caused it: two synchroniser flops, then the state register. The same wrong state also shows at once on setpoint_o and stat_n_o. A counter that fails to clear, or that counts to the wrong limit, shows as a fault or timeout entered one or more ticks too early or too late. The bench therefore counts ticks exactly at each window edge. One state, timeout with the low-current flag clear, lasts only one cycle before the restart, so the bench samples state_o in exactly that cycle.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
   typedef enum logic [2:0] {
      ST_PWRDN = 3'd0,
      ST_START = 3'd1,
      ST_PRE   = 3'd2,
      ST_FAST  = 3'd3,
      ST_EOC   = 3'd4,
      ST_TMO   = 3'd5,
      ST_FAULT = 3'd6,
      ST_SHDN  = 3'd7
   } chg_state_e;

   typedef enum logic [1:0] {
      SP_OFF  = 2'b00,
      SP_LOW  = 2'b01,
      SP_FULL = 2'b10
   } chg_setpt_e;

   // flag vector layout inside the block
   localparam int FLAG_W   = 8;
   localparam int F_VIN    = 0;
   localparam int F_HDRM   = 1;
   localparam int F_PRE    = 2;
   localparam int F_RCH    = 3;
   localparam int F_ILOW   = 4;
   localparam int F_SHDN   = 5;
   localparam int F_OT     = 6;
   localparam int F_TREC   = 7;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $error("chg_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("chg_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[s] <= '0;
            else         stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/chg_tmr.sv
module chg_tmr #(
   parameter int FAST_LIM = 12
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic clr_i,
   input  logic en_i,
   output logic short_exp_o,
   output logic long_exp_o
);
   localparam int SHORT_LIM = FAST_LIM / 6;
   localparam int CNT_W     = $clog2(FAST_LIM + 1);

   initial begin
      assert (FAST_LIM >= 6) else $error("chg_tmr: FAST_LIM must be at least 6");
      assert (FAST_LIM % 6 == 0) else $error("chg_tmr: FAST_LIM must be a multiple of 6");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cnt_q <= '0;
      else if (clr_i)                                cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_W'(FAST_LIM))  cnt_q <= cnt_q + 1'b1;
   end

   assign short_exp_o = en_i && (cnt_q >= CNT_W'(SHORT_LIM));
   assign long_exp_o  = en_i && (cnt_q >= CNT_W'(FAST_LIM));

   AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0)) else $error("counter not cleared"); // R12
   AST_NO_EXP_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> !(short_exp_o || long_exp_o)) else $error("expiry while disabled"); // R10
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
   import chg_seq_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [FLAG_W-1:0] flg_i,
   input  logic              short_exp_i,
   input  logic              long_exp_i,
   input  logic              tmr_en_i,
   output logic              chg_o,
   output chg_state_e        state_o,
   output chg_setpt_e        setpoint_o,
   output logic              stat_n_o
);
   chg_state_e state_q, state_d;

   logic vin, hdrm, pre, rch, ilow, shdn, ot, trec, restart;
   assign vin     = flg_i[F_VIN];
   assign hdrm    = flg_i[F_HDRM];
   assign pre     = flg_i[F_PRE];
   assign rch     = flg_i[F_RCH];
   assign ilow    = flg_i[F_ILOW];
   assign shdn    = flg_i[F_SHDN];
   assign ot      = flg_i[F_OT];
   assign trec    = flg_i[F_TREC];
   assign restart = !rch || !ilow;

   always_comb begin
      state_d = state_q;
      if (!vin) begin
         state_d = ST_PWRDN;
      end else if (ot && state_q != ST_FAULT && state_q != ST_PWRDN) begin
         state_d = ST_SHDN;
      end else begin
         unique case (state_q)
            ST_PWRDN: state_d = ST_START;
            ST_START: begin
               if (shdn)     state_d = ST_SHDN;
               else if (pre) state_d = ST_FAST;
               else          state_d = ST_PRE;
            end
            ST_PRE: begin
               if (pre)              state_d = ST_FAST;
               else if (short_exp_i) state_d = ST_FAULT;
            end
            ST_FAST: begin
               if (shdn)             state_d = ST_SHDN;
               else if (ilow && rch) state_d = ST_EOC;
               else if (long_exp_i)  state_d = ST_TMO;
            end
            ST_EOC: begin
               if (shdn)             state_d = ST_SHDN;
               else if (restart)     state_d = ST_START;
               else if (short_exp_i) state_d = ST_TMO;
            end
            ST_TMO: begin
               if (shdn)         state_d = ST_SHDN;
               else if (restart) state_d = ST_START;
            end
            ST_FAULT: state_d = ST_FAULT;
            ST_SHDN: begin
               if (!shdn && trec) state_d = ST_START;
            end
            default: state_d = ST_PWRDN;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_PWRDN;
      else         state_q <= state_d;
   end

   assign chg_o   = (state_d != state_q);
   assign state_o = state_q;

   always_comb begin
      setpoint_o = SP_OFF;
      if (hdrm) begin
         if (state_q == ST_PRE || state_q == ST_EOC) setpoint_o = SP_LOW;
         else if (state_q == ST_FAST)                setpoint_o = SP_FULL;
      end
   end
   assign stat_n_o = !(state_q == ST_PRE || state_q == ST_FAST);

   AST_PWRDN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vin |=> (state_q == ST_PWRDN)) else $error("supply loss ignored"); // R2
   AST_FAULT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FAULT && vin) |=> (state_q == ST_FAULT)) else $error("fault escaped"); // R5
   AST_PRE_NO_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_PRE && vin && !ot && !pre && !short_exp_i) |=> (state_q == ST_PRE))
      else $error("trickle left without cause"); // R4
   AST_OT_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vin && ot && state_q != ST_FAULT && state_q != ST_PWRDN) |=> (state_q == ST_SHDN))
      else $error("over-temperature ignored"); // R9
   AST_NO_FAULT_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tmr_en_i && state_q == ST_PRE) |=> (state_q != ST_FAULT)) else $error("fault while disabled"); // R10
   AST_OFF_NO_HDRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hdrm |-> (setpoint_o == SP_OFF)) else $error("setpoint on without headroom"); // R11
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
   import chg_seq_pkg::*;
#(
   parameter int FAST_LIM    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       vin_ok_i,
   input  logic       vin_hdrm_i,
   input  logic       bat_pre_i,
   input  logic       bat_rch_i,
   input  logic       i_low_i,
   input  logic       shdn_req_i,
   input  logic       ot_i,
   input  logic       t_rec_i,
   input  logic       tmr_en_i,
   input  logic       tick_i,
   output logic [1:0] setpoint_o,
   output logic       stat_n_o,
   output logic [2:0] state_o
);
   logic [FLAG_W-1:0] flg_raw, flg_s;
   logic              short_exp, long_exp, chg;
   chg_state_e        st;
   chg_setpt_e        sp;

   always_comb begin
      flg_raw         = '0;
      flg_raw[F_VIN]  = vin_ok_i;
      flg_raw[F_HDRM] = vin_hdrm_i;
      flg_raw[F_PRE]  = bat_pre_i;
      flg_raw[F_RCH]  = bat_rch_i;
      flg_raw[F_ILOW] = i_low_i;
      flg_raw[F_SHDN] = shdn_req_i;
      flg_raw[F_OT]   = ot_i;
      flg_raw[F_TREC] = t_rec_i;
   end

   chg_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(flg_raw), .q_o(flg_s)
   );

   chg_tmr #(.FAST_LIM(FAST_LIM)) u_tmr (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(chg),
      .en_i(tmr_en_i), .short_exp_o(short_exp), .long_exp_o(long_exp)
   );

   chg_fsm u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .flg_i(flg_s),
      .short_exp_i(short_exp), .long_exp_i(long_exp), .tmr_en_i(tmr_en_i),
      .chg_o(chg), .state_o(st), .setpoint_o(sp), .stat_n_o(stat_n_o)
   );

   assign state_o    = st;
   assign setpoint_o = sp;
endmodule

// File: tb/chg_seq_ctrl_bench.sv
`timescale 1ns/1ps
module chg_seq_ctrl_bench;
   localparam int LIM = 12;

   logic clk = 0, rst_n = 0;
   logic vin = 0, hdrm = 1, pre = 0, rch = 0, ilow = 0, shdn = 0, ot = 0, trec = 1;
   logic ten = 1, tick = 0;
   logic [1:0] sp;
   logic stn;
   logic [2:0] st;

   always #2 clk = ~clk;

   chg_seq_ctrl #(.FAST_LIM(LIM)) u_chg_seq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .vin_ok_i(vin), .vin_hdrm_i(hdrm),
      .bat_pre_i(pre), .bat_rch_i(rch), .i_low_i(ilow), .shdn_req_i(shdn),
      .ot_i(ot), .t_rec_i(trec), .tmr_en_i(ten), .tick_i(tick),
      .setpoint_o(sp), .stat_n_o(stn), .state_o(st)
   );

   typedef struct {
      logic [2:0] st;
      logic [1:0] sp;
      logic       stn;
      string      tag;
   } exp_t;

   exp_t q[$];
   int n_run = 0, n_fail = 0;
   bit done = 0;

   // monitor: compares every queued expectation just after a rising edge
   initial begin
      forever begin
         @(posedge clk); #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (st !== e.st || sp !== e.sp || stn !== e.stn) begin
               n_fail++;
               $display("FAIL %s: got state=%0d sp=%b stat_n=%b, expected state=%0d sp=%b stat_n=%b",
                        e.tag, st, sp, stn, e.st, e.sp, e.stn);
            end
         end
      end
   end

   task automatic push(input logic [2:0] s, input logic [1:0] p, input logic n, input string tag);
      exp_t e;
      e.st = s; e.sp = p; e.stn = n; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic settle_expect(input logic [2:0] s, input logic [1:0] p, input logic n, input string tag);
      repeat (6) @(negedge clk);
      push(s, p, n, tag);
      @(posedge clk); #2;
   endtask

   task automatic pulse();
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (3) @(negedge clk);
   endtask

   // tick whose expiry is observed in the exact cycle the state register takes it
   task automatic pulse_catch(input logic [2:0] s, input logic [1:0] p, input logic n, input string tag);
      @(negedge clk) tick = 1;
      @(posedge clk);
      @(negedge clk) tick = 0;
      @(posedge clk);
      push(s, p, n, tag);
      #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      push(3'd0, 2'b00, 1'b1, "R1 reset state");
      @(negedge clk) rst_n = 1;
      settle_expect(3'd0, 2'b00, 1'b1, "R1 idle without supply");

      vin = 1;
      settle_expect(3'd2, 2'b01, 1'b0, "R3 start to trickle, R11 low setpoint");
      shdn = 1;
      settle_expect(3'd2, 2'b01, 1'b0, "R4 trickle ignores shutdown");
      shdn = 0;
      pulse();
      settle_expect(3'd2, 2'b01, 1'b0, "R5 one tick short of trickle limit");
      pulse();
      settle_expect(3'd6, 2'b00, 1'b1, "R5 trickle timeout to fault");
      pre = 1; ot = 1;
      settle_expect(3'd6, 2'b00, 1'b1, "R5 R9 fault holds against cell and over-temp");
      ot = 0;
      vin = 0;
      settle_expect(3'd0, 2'b00, 1'b1, "R2 fault cleared by supply loss");
      vin = 1;
      settle_expect(3'd3, 2'b10, 1'b0, "R3 start to bulk, R11 full setpoint");
      hdrm = 0;
      settle_expect(3'd3, 2'b00, 1'b0, "R11 no headroom forces off");
      hdrm = 1;

      rch = 1;
      for (int i = 0; i < LIM - 1; i++) pulse();
      settle_expect(3'd3, 2'b10, 1'b0, "R6 bulk before limit");
      pulse_catch(3'd5, 2'b00, 1'b1, "R6 bulk timeout");
      settle_expect(3'd3, 2'b10, 1'b0, "R7 timeout restart on current flag clear");

      ilow = 1;
      settle_expect(3'd4, 2'b01, 1'b1, "R6 bulk to top-off");
      pulse();
      settle_expect(3'd4, 2'b01, 1'b1, "R7 top-off before limit");
      pulse();
      settle_expect(3'd5, 2'b00, 1'b1, "R7 top-off timeout");
      rch = 0;
      settle_expect(3'd3, 2'b10, 1'b0, "R7 timeout restart on cell sag");
      rch = 1;
      settle_expect(3'd4, 2'b01, 1'b1, "R6 back to top-off");
      ilow = 0;
      settle_expect(3'd3, 2'b10, 1'b0, "R7 top-off restart on current rise");

      shdn = 1;
      settle_expect(3'd7, 2'b00, 1'b1, "R8 bulk to shutdown");
      trec = 0; shdn = 0;
      settle_expect(3'd7, 2'b00, 1'b1, "R8 held without temperature recovery");
      trec = 1;
      settle_expect(3'd3, 2'b10, 1'b0, "R8 shutdown released");
      ot = 1;
      settle_expect(3'd7, 2'b00, 1'b1, "R9 over-temp forces shutdown");
      ot = 0;
      settle_expect(3'd3, 2'b10, 1'b0, "R9 recovery after over-temp");

      vin = 0; pre = 0;
      settle_expect(3'd0, 2'b00, 1'b1, "R2 supply loss from bulk");
      vin = 1;
      settle_expect(3'd2, 2'b01, 1'b0, "R12 trickle again");
      pulse();
      pre = 1;
      settle_expect(3'd3, 2'b10, 1'b0, "R4 trickle to bulk");
      for (int i = 0; i < LIM - 1; i++) pulse();
      settle_expect(3'd3, 2'b10, 1'b0, "R12 counter cleared on state change");
      ten = 0;
      for (int i = 0; i < 5; i++) pulse();
      settle_expect(3'd3, 2'b10, 1'b0, "R10 no timeout when disabled");

      shdn = 1; vin = 0;
      settle_expect(3'd0, 2'b00, 1'b1, "R2 supply loss wins over shutdown");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule